// File: doc/BRIEF.md
# Coprocessor Two-Beat Load/Store Sequencer

This block sits between a 32-bit host data bus and a coprocessor register file of sixteen 64-bit entries. It steps through coprocessor load and store instructions one data beat at a time. A transfer is either one word (a single-precision float or a 32-bit integer) or two words (a double or a 64-bit integer). For every beat it answers either "increment" (another word follows) or "done". On a load the bus word is written into the addressed register half. On a store the selected half comes out on the store-data port.

An instruction starts with a non-data beat, which rearms the sequencer. Data beats follow. A three-state machine tracks progress: `SEQ_IDLE` (armed, the next data beat is a first word), `SEQ_SECOND` (the first word of a long transfer has been taken) and `SEQ_SPENT` (the transfer is complete). The transitions are:
- *arm*: any state to `SEQ_IDLE` on a non-data beat.
- *open*: `SEQ_IDLE` to `SEQ_SECOND` on a long data beat.
- *close-single*: `SEQ_IDLE` to `SEQ_SPENT` on a single data beat.
- *close-long*: `SEQ_SECOND` to `SEQ_SPENT` on the next data beat.
- *hold*: `SEQ_SPENT` stays in `SEQ_SPENT` on data beats.

All responses are registered and appear one clock after the beat. The register file updates on the same clock edge.

Top module: `cp_ldst_seq`

## Requirements
- R1: After reset `rsp_valid`, `rsp_done`, `wr_hi`, `wr_lo` and `st_data` are 0, and every register reads back as zero.
- R2: A non-data beat (`beat_is_data`=0) answers done with no register write and `st_data`=0, and it rearms the sequencer so that the next data beat is treated as a first word, also in the middle of a long transfer.
- R3: The register addressed is `instr[15:12]`, and `wr_idx` shows it on every response.
- R4: With `instr[22]`=1 (long transfer), the first data beat answers increment (`rsp_done`=0) and the second answers done. With `instr[22]`=0 a single data beat answers done.
- R5: On a long load, the first word is written to bits 63:32 when `big_endian`=1 and to bits 31:0 when `big_endian`=0. The second word goes to the other half.
- R6: On a long store, the first beat outputs bits 63:32 when `big_endian`=1 and bits 31:0 otherwise. The second beat outputs the other half.
- R7: A single-word load with `is_float`=1 writes bits 63:32 only (`wr_hi`=1, `wr_lo`=0). Bits 31:0 keep their value.
- R8: A single-word load with `is_float`=0 writes the word to bits 31:0 and copies its bit 31 into all of bits 63:32.
- R9: A single-word store outputs bits 63:32 when `is_float`=1 and bits 31:0 when `is_float`=0.
- R10: After a transfer is complete, further data beats are ignored until a non-data beat: they answer done, write nothing and give `st_data`=0.
- R11: `rsp_valid` is 1 exactly in the cycle after a cycle with `beat_valid`=1.
- R12: A store beat never asserts `wr_hi` or `wr_lo`. A load beat always gives `st_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| beat_valid | input | 1 | A beat is presented this cycle |
| beat_is_data | input | 1 | 1: data beat, 0: non-data (arming) beat |
| is_load | input | 1 | 1: load instruction, 0: store |
| instr | input | 32 | Instruction word; bit 22 selects long, bits 15:12 the register |
| bus_wdata | input | 32 | Word from the host bus for loads |
| big_endian | input | 1 | Word order of long transfers |
| is_float | input | 1 | Class select for single transfers: 1 float, 0 integer |
| rsp_valid | output | 1 | Response for the previous cycle's beat |
| rsp_done | output | 1 | 1: done, 0: increment |
| st_data | output | 32 | Word to the host bus for stores |
| wr_hi | output | 1 | Bits 63:32 of the register were written |
| wr_lo | output | 1 | Bits 31:0 of the register were written |
| wr_idx | output | 4 | Register addressed by the beat |

## Verification
Two functions can fall in the same cycle: the arming reset of the sequencer and the pending second word of a long transfer. This happens when a non-data beat arrives while `SEQ_SECOND` is held. The bench provokes it with random beat types that are not aligned to transfer boundaries, and with one directed abort. It judges the outcome through a reference model: the aborted beat must answer done and write nothing, and the next data beat must act as a first word. A later store then shows that the half which was never written keeps its old value.

// File: rtl/cpls_pkg.sv
package cpls_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_SECOND = 2'd1,
        SEQ_SPENT  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/cpls_seq_fsm.sv
module cpls_seq_fsm
    import cpls_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic beat_valid,
    input  logic beat_is_data,
    input  logic long_req,
    output logic act,
    output logic first_word,
    output logic fin
);
    seq_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        act        = 1'b0;
        first_word = 1'b0;
        fin        = 1'b1;
        if (beat_valid) begin
            if (!beat_is_data) begin
                state_d = SEQ_IDLE;
            end else begin
                unique case (state_q)
                    SEQ_IDLE: begin
                        act        = 1'b1;
                        first_word = 1'b1;
                        fin        = !long_req;
                        state_d    = long_req ? SEQ_SECOND : SEQ_SPENT;
                    end
                    SEQ_SECOND: begin
                        act     = 1'b1;
                        state_d = SEQ_SPENT;
                    end
                    SEQ_SPENT: state_d = SEQ_SPENT;
                    default:   state_d = SEQ_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/cpls_lane_map.sv
module cpls_lane_map #(
    parameter int WORD_W = 32
) (
    input  logic              act,
    input  logic              is_load,
    input  logic              long_req,
    input  logic              first_word,
    input  logic              big_endian,
    input  logic              is_float,
    input  logic [WORD_W-1:0] bus_word,
    output logic              upper_sel,
    output logic              we_hi,
    output logic              we_lo,
    output logic [WORD_W-1:0] hi_val,
    output logic [WORD_W-1:0] lo_val
);
    always_comb begin
        if (long_req) upper_sel = first_word ? big_endian : !big_endian;
        else          upper_sel = is_float;
        we_hi  = 1'b0;
        we_lo  = 1'b0;
        hi_val = bus_word;
        lo_val = bus_word;
        if (act && is_load) begin
            if (long_req) begin
                we_hi = upper_sel;
                we_lo = !upper_sel;
            end else if (is_float) begin
                we_hi = 1'b1;
            end else begin
                we_hi  = 1'b1;
                we_lo  = 1'b1;
                hi_val = {WORD_W{bus_word[WORD_W-1]}};
            end
        end
    end
endmodule

// File: rtl/cpls_regfile.sv
module cpls_regfile #(
    parameter int NUM_REGS = 16,
    parameter int WORD_W   = 32,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic              we_hi,
    input  logic              we_lo,
    input  logic [WORD_W-1:0] hi_val,
    input  logic [WORD_W-1:0] lo_val,
    output logic [WORD_W-1:0] rd_hi,
    output logic [WORD_W-1:0] rd_lo
);
    logic [WORD_W-1:0] hi_q [NUM_REGS];
    logic [WORD_W-1:0] lo_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hi_q[g] <= '0;
                lo_q[g] <= '0;
            end else if (idx == IDX_W'(g)) begin
                if (we_hi) hi_q[g] <= hi_val;
                if (we_lo) lo_q[g] <= lo_val;
            end
        end
    end

    assign rd_hi = hi_q[idx];
    assign rd_lo = lo_q[idx];
endmodule

// File: rtl/cp_ldst_seq.sv
module cp_ldst_seq #(
    parameter int NUM_REGS = 16,
    parameter int WORD_W   = 32,
    parameter int INSTR_W  = 32,
    parameter int LONG_BIT = 22,
    parameter int IDX_LSB  = 12,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               beat_valid,
    input  logic               beat_is_data,
    input  logic               is_load,
    input  logic [INSTR_W-1:0] instr,
    input  logic [WORD_W-1:0]  bus_wdata,
    input  logic               big_endian,
    input  logic               is_float,
    output logic               rsp_valid,
    output logic               rsp_done,
    output logic [WORD_W-1:0]  st_data,
    output logic               wr_hi,
    output logic               wr_lo,
    output logic [IDX_W-1:0]   wr_idx
);
    logic              long_req, act, first_word, fin;
    logic              upper_sel, we_hi, we_lo;
    logic [WORD_W-1:0] hi_val, lo_val, rd_hi, rd_lo;
    logic [IDX_W-1:0]  idx;

    assign long_req = instr[LONG_BIT];
    assign idx      = instr[IDX_LSB +: IDX_W];

    cpls_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .beat_valid(beat_valid),
        .beat_is_data(beat_is_data), .long_req(long_req),
        .act(act), .first_word(first_word), .fin(fin)
    );

    cpls_lane_map #(.WORD_W(WORD_W)) u_map (
        .act(act), .is_load(is_load), .long_req(long_req),
        .first_word(first_word), .big_endian(big_endian),
        .is_float(is_float), .bus_word(bus_wdata),
        .upper_sel(upper_sel), .we_hi(we_hi), .we_lo(we_lo),
        .hi_val(hi_val), .lo_val(lo_val)
    );

    cpls_regfile #(.NUM_REGS(NUM_REGS), .WORD_W(WORD_W)) u_rf (
        .clk(clk), .rst_n(rst_n), .idx(idx), .we_hi(we_hi), .we_lo(we_lo),
        .hi_val(hi_val), .lo_val(lo_val), .rd_hi(rd_hi), .rd_lo(rd_lo)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_done  <= 1'b0;
            st_data   <= '0;
            wr_hi     <= 1'b0;
            wr_lo     <= 1'b0;
            wr_idx    <= '0;
        end else begin
            rsp_valid <= beat_valid;
            rsp_done  <= beat_valid && fin;
            wr_hi     <= we_hi;
            wr_lo     <= we_lo;
            wr_idx    <= idx;
            if (act && !is_load) st_data <= upper_sel ? rd_hi : rd_lo;
            else                 st_data <= '0;
        end
    end
endmodule

// File: rtl/cp_ldst_seq_chk.sv
module cp_ldst_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        beat_valid,
    input logic        beat_is_data,
    input logic        is_load,
    input logic [31:0] instr,
    input logic        is_float,
    input logic        rsp_valid,
    input logic        rsp_done,
    input logic [31:0] st_data,
    input logic        wr_hi,
    input logic        wr_lo,
    input logic [3:0]  wr_idx
);
    logic armed;
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R11
    rsp_follows_beat_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        rsp_valid == $past(beat_valid));

    // R2
    arm_beat_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && !beat_is_data |=> rsp_done && !wr_hi && !wr_lo && st_data == 32'd0);

    // R12
    store_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && !is_load |=> !wr_hi && !wr_lo);

    // R12
    load_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && is_load |=> st_data == 32'd0);

    // R7
    float_single_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && beat_is_data && is_load && !instr[22] && is_float |=> !wr_lo);

    // R3
    idx_follows_instr_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (wr_hi || wr_lo) |-> wr_idx == $past(instr[15:12]));
endmodule

bind cp_ldst_seq cp_ldst_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .beat_valid(beat_valid), .beat_is_data(beat_is_data),
    .is_load(is_load), .instr(instr), .is_float(is_float), .rsp_valid(rsp_valid),
    .rsp_done(rsp_done), .st_data(st_data), .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_idx(wr_idx)
);

// File: tb/cp_ldst_seq_test.sv
`timescale 1ns/1ps
module cp_ldst_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        beat_valid = 1'b0, beat_is_data = 1'b0, is_load = 1'b0;
    logic [31:0] instr = '0, bus_wdata = '0;
    logic        big_endian = 1'b0, is_float = 1'b0;
    logic        rsp_valid, rsp_done, wr_hi, wr_lo;
    logic [31:0] st_data;
    logic [3:0]  wr_idx;

    int errors = 0;
    int checks = 0;

    // reference model state
    logic [63:0] mreg [16];
    int          mstate = 0;  // 0 armed, 1 second pending, 2 complete

    always #2 clk = ~clk;

    cp_ldst_seq uut (
        .clk(clk), .rst_n(rst_n), .beat_valid(beat_valid), .beat_is_data(beat_is_data),
        .is_load(is_load), .instr(instr), .bus_wdata(bus_wdata), .big_endian(big_endian),
        .is_float(is_float), .rsp_valid(rsp_valid), .rsp_done(rsp_done), .st_data(st_data),
        .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_idx(wr_idx)
    );

    task automatic check(input string tag, input logic [38:0] act_v, input logic [38:0] exp_v);
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act_v, exp_v);
        end
    endtask

    function automatic logic [31:0] mk_instr(input logic lng, input logic [3:0] r);
        logic [31:0] w = $urandom();
        w[22] = lng;
        w[15:12] = r;
        return w;
    endfunction

    // one beat: drive, let it be registered, then compare with the model
    task automatic beat(input string tag, input logic dat, input logic ld, input logic lng,
                        input logic [3:0] r, input logic [31:0] d, input logic be, input logic fl);
        logic        e_done, e_hi, e_lo, up, first;
        logic [31:0] e_st;
        @(negedge clk);
        beat_valid = 1'b1; beat_is_data = dat; is_load = ld; instr = mk_instr(lng, r);
        bus_wdata = d; big_endian = be; is_float = fl;
        e_done = 1'b1; e_hi = 1'b0; e_lo = 1'b0; e_st = '0;
        if (!dat) begin
            mstate = 0;
        end else if (mstate != 2) begin
            first = (mstate == 0);
            up = lng ? (first ? be : !be) : fl;
            if (ld) begin
                if (lng) begin
                    if (up) mreg[r][63:32] = d; else mreg[r][31:0] = d;
                    e_hi = up; e_lo = !up;
                end else if (fl) begin
                    mreg[r][63:32] = d; e_hi = 1'b1;
                end else begin
                    mreg[r] = {{32{d[31]}}, d}; e_hi = 1'b1; e_lo = 1'b1;
                end
            end else begin
                e_st = up ? mreg[r][63:32] : mreg[r][31:0];
            end
            e_done = !(lng && first);
            mstate = (lng && first) ? 1 : 2;
        end
        @(negedge clk);
        beat_valid = 1'b0;
        check(tag, {rsp_valid, rsp_done, wr_hi, wr_lo, wr_idx, st_data},
                   {1'b1, e_done, e_hi, e_lo, r, e_st});
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #600000;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20250611));
        for (int i = 0; i < 16; i++) mreg[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", {rsp_valid, rsp_done, wr_hi, wr_lo, 3'b000, st_data}, 39'd0);
        rst_n = 1'b1;
        beat("R1", 0, 0, 0, 4'd9, 0, 0, 0);
        beat("R1", 1, 0, 1, 4'd9, 0, 1, 0);
        beat("R1", 1, 0, 1, 4'd9, 0, 1, 0);
        @(negedge clk);
        check("R11", {38'd0, rsp_valid}, 39'd0);
        // R5 R4 R3 long load big endian into r5: first word high
        beat("R2", 0, 1, 1, 4'd5, 0, 1, 0);
        beat("R4 R5", 1, 1, 1, 4'd5, 32'hAAAA_0001, 1, 0);
        beat("R4 R5 R3", 1, 1, 1, 4'd5, 32'hBBBB_0002, 1, 0);
        // R10 ignored beat after completion
        beat("R10", 1, 1, 1, 4'd5, 32'hDEAD_BEEF, 1, 0);
        // R9 single stores read halves
        beat("R2", 0, 0, 0, 4'd5, 0, 0, 0);
        beat("R9 R10", 1, 0, 0, 4'd5, 0, 0, 0);
        check("R5", {7'd0, st_data}, {7'd0, 32'hBBBB_0002});
        beat("R2", 0, 0, 0, 4'd5, 0, 0, 1);
        beat("R9", 1, 0, 0, 4'd5, 0, 0, 1);
        check("R5", {7'd0, st_data}, {7'd0, 32'hAAAA_0001});
        // R6 long store little endian: first beat low half
        beat("R2", 0, 0, 1, 4'd5, 0, 0, 0);
        beat("R6", 1, 0, 1, 4'd5, 0, 0, 0);
        check("R6", {7'd0, st_data}, {7'd0, 32'hBBBB_0002});
        beat("R6", 1, 0, 1, 4'd5, 0, 0, 0);
        check("R6", {7'd0, st_data}, {7'd0, 32'hAAAA_0001});
        // R8 sign extension, R7 float keeps low half
        beat("R2", 0, 1, 0, 4'd15, 0, 0, 0);
        beat("R8", 1, 1, 0, 4'd15, 32'h8000_0007, 0, 0);
        beat("R2", 0, 0, 0, 4'd15, 0, 0, 1);
        beat("R8", 1, 0, 0, 4'd15, 0, 0, 1);
        check("R8", {7'd0, st_data}, {7'd0, 32'hFFFF_FFFF});
        beat("R2", 0, 1, 0, 4'd15, 0, 0, 1);
        beat("R7", 1, 1, 0, 4'd15, 32'h3F80_0000, 0, 1);
        beat("R2", 0, 0, 0, 4'd15, 0, 0, 0);
        beat("R7", 1, 0, 0, 4'd15, 0, 0, 0);
        check("R7", {7'd0, st_data}, {7'd0, 32'h8000_0007});
        // R2 abort mid long load, then fresh first word
        beat("R2", 0, 1, 1, 4'd2, 0, 0, 0);
        beat("R2", 1, 1, 1, 4'd2, 32'h1111_1111, 0, 0);
        beat("R2", 0, 1, 1, 4'd2, 0, 0, 0);
        beat("R2", 1, 1, 1, 4'd2, 32'h2222_2222, 0, 0);
        check("R2", {38'd0, rsp_done}, 39'd0);
        // constrained random mix
        for (int n = 0; n < 600; n++) begin
            logic dat = ($urandom_range(9) > 2);
            beat("R2 R4 R5 R6 R7 R8 R9 R10 R12", dat, 1'($urandom()), 1'($urandom()),
                 4'($urandom_range(3)), $urandom(), 1'($urandom()), 1'($urandom()));
        end
        finish_run();
    end
endmodule